// File: doc/BRIEF.md
# Multi-Mode Compare Timer

This block is a memory-mapped 24-bit up-counter that runs in one of three operating modes chosen by a two-bit field: an interval timer, a pulse generator that toggles a flip-flop output, or a watchdog. A fourth setting stops the counter. The mode field acts as the block's state. There are four states: INTERVAL (0), PULSE (1), WATCHDOG (2) and OFF (3). Software moves the block between them by writing the control register, and any state can be reached from any other in one write.

A prescaler produces the count steps. The step source is either the internal tick input or the external tick input. Both are single-cycle enables in the block's own clock domain. On the internal source the prescaler can divide by a power of two. Two 24-bit compare registers, A and B, set the trip points. Each step is one of these events:
- plain increment (STEP)
- interval arrival at A (IV_HIT)
- pulse trip at A (PG_A)
- pulse trip at B (PG_B)
- watchdog expiry at A (WD_HIT)

Every event sets a sticky status bit. When the matching enable is set, it also raises a level interrupt that stays high until software writes the status register.

The register bus uses a byte address whose two low bits are ignored. Writes are whole words. Read data is combinational from the address.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count, control, status, interval-mode, divider, pulse-mode and watchdog-mode registers read 0. Compare A (0x08) and compare B (0x0C) read 0xFFFFFF. `irq` and `ff_out` are 0.
- R2: A write to control (0x00) stores `wdata[7:0]` with bit 4 forced to 0. The control fields are:
  - bit 7: run enable
  - bit 6: divider enable
  - bit 5: clear-on-stop
  - bit 2: source select (1 = external)
  - bits 1:0: mode
- R3: A control write whose data has bit 7 = 0 and bit 5 = 1 sets the count to 0 at that edge. That write also cancels any count step, and its event, in the same cycle.
- R4: With the internal source and the divider off, each cycle with `tick_int` high is one step. With the divider on, every 2^(1+D)-th `tick_int` pulse is a step, where D is divider register (0x20) bits 2:0. With the external source, each `tick_ext` pulse is a step and the divider is ignored. The prescaler restarts from zero whenever the counter is not running.
- R5: In INTERVAL mode the counter steps only while run enable is 1 and the count differs from A. The step that reaches A sets status bit 0 and raises `irq` if interval-mode (0x10) bit 15 is set. If 0x10 bit 0 is set, that step puts the count at 0. Otherwise the count holds at A with no further events.
- R6: In PULSE mode the counter steps while run enable is 1. On a step whose next value equals A, `ff_out` toggles, status bit 1 is set, and `irq` is raised if pulse-mode (0x30) bit 14 is set. Otherwise, on a step whose next value equals B, `ff_out` toggles, status bit 2 is set, `irq` is raised if 0x30 bit 15 is set, and the count goes to 0. `ff_out` changes in no other mode.
- R7: In WATCHDOG mode the counter steps unless run enable is 0 and watchdog-mode (0x40) bit 7 is 1. On a step whose next value equals A, status bit 3 is set, `irq` is raised if 0x40 bit 15 is set, and the count goes to 0.
- R8: In OFF mode the count never changes, except through R3.
- R9: Any write to status (0x04) clears all four status bits and `irq`. An event in that same cycle still sets its bit and, if enabled, `irq`.
- R10: `irq` is a level signal. It stays high until a status write, and it is never high while status is 0.
- R11: Compare registers keep only `wdata[23:0]`. The count reads at 0xF0. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal tick enable |
| tick_ext | input | 1 | External tick enable, synchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| ff_out | output | 1 | Pulse flip-flop output |

## Verification
The bench targets four corner cases:
- **Interval hold at A without zero-clear.** A design that keeps stepping past A would wrap and raise repeat interrupts.
- **Status write in the same cycle as an event.** If the clear won, the event would be lost and `irq` would drop.
- **Precedence of the B trip point.** Compare A must take priority over compare B, and the count must return to zero on B. A wrong design would toggle `ff_out` at the wrong phase.
- **Watchdog halt rule.** Counting must depend on both run enable and the disable bit. A wrong design would either freeze a watchdog that is meant to run or keep counting one that is meant to stop.

Divider ratios and the ignored divider on the external source are checked by exact step counts. A per-cycle reference model catches timing slips of one cycle.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    localparam int CNT_W  = 24;
    localparam int DIV_W  = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_PULSE    = 2'd1,
        MODE_WATCHDOG = 2'd2,
        MODE_OFF      = 2'd3
    } tmode_e;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_STEP,
        EV_IV_HIT,
        EV_PG_A,
        EV_PG_B,
        EV_WD_HIT
    } tevent_e;

    // word indices (byte offset / 4)
    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_CMPA = 2;
    localparam int IDX_CMPB = 3;
    localparam int IDX_IVM  = 4;
    localparam int IDX_DIV  = 8;
    localparam int IDX_PGM  = 12;
    localparam int IDX_WDM  = 16;
    localparam int IDX_CNT  = 60;

    // control field positions
    localparam int CB_RUN  = 7;
    localparam int CB_DIVE = 6;
    localparam int CB_CLR  = 5;
    localparam int CB_HOLE = 4;
    localparam int CB_EXT  = 2;

    // mode register field positions
    localparam int MB_HI_EN = 15;
    localparam int MB_A_EN  = 14;
    localparam int MB_WDIS  = 7;
    localparam int MB_LOW   = 0;

endpackage

// File: rtl/cmpt_regs.sv
module cmpt_regs
    import cmpt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DIV_W,
    parameter int AW = ADDR_W,
    parameter int BW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    input  logic [CW-1:0] count,
    input  logic [3:0]    status,
    output logic [BW-1:0] bus_rdata,
    output logic [7:0]    ctrl,
    output logic [CW-1:0] cmpa,
    output logic [CW-1:0] cmpb,
    output logic          iv_irq_en,
    output logic          iv_zero_clr,
    output logic [DW-1:0] cdr,
    output logic          pg_a_en,
    output logic          pg_b_en,
    output logic          pg_ffi,
    output logic          wd_irq_en,
    output logic          wd_dis,
    output logic          status_wr,
    output logic          cnt_clr
);

    localparam int WIW = AW - 2;
    localparam logic [CW-1:0] CMP_RST = '1;

    logic [WIW-1:0] widx;
    assign widx = bus_addr[AW-1:2];

    function automatic logic hit(input logic [WIW-1:0] w, input int idx);
        return int'(w) == idx;
    endfunction

    assign status_wr = bus_wr && hit(widx, IDX_STAT);
    assign cnt_clr   = bus_wr && hit(widx, IDX_CTRL)
                       && !bus_wdata[CB_RUN] && bus_wdata[CB_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl        <= '0;
            cmpa        <= CMP_RST;
            cmpb        <= CMP_RST;
            iv_irq_en   <= 1'b0;
            iv_zero_clr <= 1'b0;
            cdr         <= '0;
            pg_a_en     <= 1'b0;
            pg_b_en     <= 1'b0;
            pg_ffi      <= 1'b0;
            wd_irq_en   <= 1'b0;
            wd_dis      <= 1'b0;
        end else if (bus_wr) begin
            if (hit(widx, IDX_CTRL)) begin
                ctrl          <= bus_wdata[7:0];
                ctrl[CB_HOLE] <= 1'b0;
            end
            if (hit(widx, IDX_CMPA)) cmpa <= bus_wdata[CW-1:0];
            if (hit(widx, IDX_CMPB)) cmpb <= bus_wdata[CW-1:0];
            if (hit(widx, IDX_IVM)) begin
                iv_irq_en   <= bus_wdata[MB_HI_EN];
                iv_zero_clr <= bus_wdata[MB_LOW];
            end
            if (hit(widx, IDX_DIV)) cdr <= bus_wdata[DW-1:0];
            if (hit(widx, IDX_PGM)) begin
                pg_b_en <= bus_wdata[MB_HI_EN];
                pg_a_en <= bus_wdata[MB_A_EN];
                pg_ffi  <= bus_wdata[MB_LOW];
            end
            if (hit(widx, IDX_WDM)) begin
                wd_irq_en <= bus_wdata[MB_HI_EN];
                wd_dis    <= bus_wdata[MB_WDIS];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (int'(widx))
            IDX_CTRL: bus_rdata[7:0]    = ctrl;
            IDX_STAT: bus_rdata[3:0]    = status;
            IDX_CMPA: bus_rdata[CW-1:0] = cmpa;
            IDX_CMPB: bus_rdata[CW-1:0] = cmpb;
            IDX_IVM: begin
                bus_rdata[MB_HI_EN] = iv_irq_en;
                bus_rdata[MB_LOW]   = iv_zero_clr;
            end
            IDX_DIV:  bus_rdata[DW-1:0] = cdr;
            IDX_PGM: begin
                bus_rdata[MB_HI_EN] = pg_b_en;
                bus_rdata[MB_A_EN]  = pg_a_en;
                bus_rdata[MB_LOW]   = pg_ffi;
            end
            IDX_WDM: begin
                bus_rdata[MB_HI_EN] = wd_irq_en;
                bus_rdata[MB_WDIS]  = wd_dis;
            end
            IDX_CNT:  bus_rdata[CW-1:0] = count;
            default:  bus_rdata = '0;
        endcase
    end

    AST_CTRL_CLR_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> !ctrl[CB_RUN] && ctrl[CB_CLR]) else $error("clear without stop"); // R3

endmodule

// File: rtl/cmpt_prescale.sv
module cmpt_prescale
    import cmpt_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          src_tick,
    input  logic          div_en,
    input  logic [DW-1:0] cdr,
    output logic          step
);

    localparam int PS_W = (1 << DW) + 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] lim;
    logic            wrap;

    assign lim  = PS_W'((1 << (int'(cdr) + 1)) - 1);
    assign wrap = ps_q >= lim;
    assign step = run && src_tick && (!div_en || wrap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (!run) begin
            ps_q <= '0;
        end else if (src_tick) begin
            if (!div_en || wrap) ps_q <= '0;
            else                 ps_q <= ps_q + 1'b1;
        end
    end

    AST_PS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ps_q == '0) else $error("prescaler kept state"); // R4

    AST_PS_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !src_tick |-> !step) else $error("step without tick"); // R4

endmodule

// File: rtl/cmpt_core.sv
module cmpt_core
    import cmpt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          tce,
    input  logic          wd_dis,
    input  logic [CW-1:0] cmpa,
    input  logic [CW-1:0] cmpb,
    input  logic          iv_irq_en,
    input  logic          iv_zero_clr,
    input  logic          pg_a_en,
    input  logic          pg_b_en,
    input  logic          wd_irq_en,
    input  logic          step,
    input  logic          cnt_clr,
    input  logic          status_wr,
    output logic          run,
    output logic [CW-1:0] count,
    output logic [3:0]    status,
    output logic          irq,
    output logic          ff
);

    tmode_e        st_mode;
    tevent_e       ev;
    logic [CW-1:0] nxt;
    logic [CW-1:0] cnt_d;
    logic [3:0]    st_set;
    logic          irq_set;
    logic          ff_flip;

    assign st_mode = tmode_e'(mode);
    assign nxt     = count + 1'b1;

    // run condition per mode state
    always_comb begin
        unique case (st_mode)
            MODE_INTERVAL: run = tce && (count != cmpa);
            MODE_PULSE:    run = tce;
            MODE_WATCHDOG: run = tce || !wd_dis;
            MODE_OFF:      run = 1'b0;
        endcase
    end

    // event classification
    always_comb begin
        ev = EV_IDLE;
        if (step && !cnt_clr) begin
            ev = EV_STEP;
            unique case (st_mode)
                MODE_INTERVAL: if (nxt == cmpa) ev = EV_IV_HIT;
                MODE_PULSE: begin
                    if (nxt == cmpa)      ev = EV_PG_A;
                    else if (nxt == cmpb) ev = EV_PG_B;
                end
                MODE_WATCHDOG: if (nxt == cmpa) ev = EV_WD_HIT;
                MODE_OFF:      ev = EV_IDLE;
            endcase
        end
    end

    // event outputs
    always_comb begin
        cnt_d   = count;
        st_set  = '0;
        irq_set = 1'b0;
        ff_flip = 1'b0;
        unique case (ev)
            EV_IDLE: cnt_d = count;
            EV_STEP: cnt_d = nxt;
            EV_IV_HIT: begin
                cnt_d     = iv_zero_clr ? '0 : nxt;
                st_set[0] = 1'b1;
                irq_set   = iv_irq_en;
            end
            EV_PG_A: begin
                cnt_d     = nxt;
                st_set[1] = 1'b1;
                irq_set   = pg_a_en;
                ff_flip   = 1'b1;
            end
            EV_PG_B: begin
                cnt_d     = '0;
                st_set[2] = 1'b1;
                irq_set   = pg_b_en;
                ff_flip   = 1'b1;
            end
            EV_WD_HIT: begin
                cnt_d     = '0;
                st_set[3] = 1'b1;
                irq_set   = wd_irq_en;
            end
            default: cnt_d = count;
        endcase
        if (cnt_clr) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            status <= '0;
            irq    <= 1'b0;
            ff     <= 1'b0;
        end else begin
            count  <= cnt_d;
            status <= (status_wr ? 4'b0 : status) | st_set;
            irq    <= (status_wr ? 1'b0 : irq) | irq_set;
            ff     <= ff ^ ff_flip;
        end
    end

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mode == MODE_OFF && !cnt_clr) |=> $stable(count)) else $error("count moved while off"); // R8
    AST_IRQ_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 4'b0)) else $error("irq without status"); // R10
    AST_STATUS_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && st_set == 4'b0) |=> (status == 4'b0 && !irq)) else $error("status not cleared"); // R9
    AST_IV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mode == MODE_INTERVAL && count == cmpa && !cnt_clr) |=> $stable(count)) else $error("interval left A"); // R5
    AST_FF_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ff) |-> $past(st_mode) == MODE_PULSE) else $error("ff moved outside pulse"); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> count == '0) else $error("clear missed"); // R3
    AST_WD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mode == MODE_WATCHDOG && step && !cnt_clr && nxt == cmpa) |=> (count == '0 && status[3])) else $error("watchdog expiry"); // R7

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmpt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DIV_W,
    parameter int AW = ADDR_W,
    parameter int BW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_int,
    input  logic          tick_ext,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          irq,
    output logic          ff_out
);

    logic [7:0]    ctrl;
    logic [CW-1:0] cmpa, cmpb, count;
    logic [DW-1:0] cdr;
    logic [3:0]    status;
    logic iv_irq_en, iv_zero_clr, pg_a_en, pg_b_en, pg_ffi;
    logic wd_irq_en, wd_dis, status_wr, cnt_clr;
    logic run, step, src_tick, div_en;

    assign src_tick = ctrl[CB_EXT] ? tick_ext : tick_int;
    assign div_en   = ctrl[CB_DIVE] && !ctrl[CB_EXT];

    cmpt_regs #(.CW(CW), .DW(DW), .AW(AW), .BW(BW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .status(status),
        .bus_rdata(bus_rdata), .ctrl(ctrl), .cmpa(cmpa), .cmpb(cmpb),
        .iv_irq_en(iv_irq_en), .iv_zero_clr(iv_zero_clr), .cdr(cdr),
        .pg_a_en(pg_a_en), .pg_b_en(pg_b_en), .pg_ffi(pg_ffi),
        .wd_irq_en(wd_irq_en), .wd_dis(wd_dis),
        .status_wr(status_wr), .cnt_clr(cnt_clr)
    );

    cmpt_prescale #(.DW(DW)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(run), .src_tick(src_tick),
        .div_en(div_en), .cdr(cdr), .step(step)
    );

    cmpt_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(ctrl[1:0]), .tce(ctrl[CB_RUN]),
        .wd_dis(wd_dis), .cmpa(cmpa), .cmpb(cmpb),
        .iv_irq_en(iv_irq_en), .iv_zero_clr(iv_zero_clr),
        .pg_a_en(pg_a_en), .pg_b_en(pg_b_en), .wd_irq_en(wd_irq_en),
        .step(step), .cnt_clr(cnt_clr), .status_wr(status_wr),
        .run(run), .count(count), .status(status), .irq(irq), .ff(ff_out)
    );

    // initial-level bit is held for readback only; flip-flop resets to its reset value
    logic unused_ffi;
    assign unused_ffi = pg_ffi;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !ff_out)) else $error("dirty reset"); // R1

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_int = 1'b0, tick_ext = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, ff_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .ff_out(ff_out)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_ctrl;
    logic [23:0] m_cmpa, m_cmpb, m_cnt;
    logic [31:0] m_iv, m_pg, m_wd;
    logic [2:0]  m_div;
    logic [3:0]  m_st;
    logic        m_irq, m_ff;
    int          m_ps;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (int'(a[7:2]))
            0:  return {24'h0, m_ctrl};
            1:  return {28'h0, m_st};
            2:  return {8'h0, m_cmpa};
            3:  return {8'h0, m_cmpb};
            4:  return m_iv;
            8:  return {29'h0, m_div};
            12: return m_pg;
            16: return m_wd;
            60: return {8'h0, m_cnt};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'h0; m_cmpa = 24'hFFFFFF; m_cmpb = 24'hFFFFFF; m_cnt = 24'h0;
            m_iv = 0; m_pg = 0; m_wd = 0; m_div = 0; m_st = 0;
            m_irq = 0; m_ff = 0; m_ps = 0;
        end else begin
            int md, n, w;
            bit tce, ext, dven, run, src, step, clr, ir;
            logic [23:0] nx, c;
            logic [3:0] st;
            md = int'(m_ctrl[1:0]); tce = m_ctrl[7]; ext = m_ctrl[2];
            dven = m_ctrl[6] && !ext;
            case (md)
                0: run = tce && (m_cnt != m_cmpa);
                1: run = tce;
                2: run = tce || !m_wd[7];
                default: run = 0;
            endcase
            src = ext ? tick_ext : tick_int;
            step = 0;
            if (!run) m_ps = 0;
            else if (src) begin
                if (!dven) begin step = 1; m_ps = 0; end
                else begin
                    n = 1 << (int'(m_div) + 1);
                    if (m_ps + 1 >= n) begin step = 1; m_ps = 0; end
                    else m_ps = m_ps + 1;
                end
            end
            w = int'(bus_addr[7:2]);
            clr = bus_wr && w == 0 && !bus_wdata[7] && bus_wdata[5];
            st = m_st; ir = m_irq; c = m_cnt;
            if (bus_wr && w == 1) begin st = 0; ir = 0; end
            if (clr) c = 0;
            else if (step) begin
                nx = m_cnt + 24'd1; c = nx;
                if (md == 0 && nx == m_cmpa) begin
                    st[0] = 1; if (m_iv[15]) ir = 1; if (m_iv[0]) c = 0;
                end else if (md == 1 && nx == m_cmpa) begin
                    st[1] = 1; if (m_pg[14]) ir = 1; m_ff = ~m_ff;
                end else if (md == 1 && nx == m_cmpb) begin
                    st[2] = 1; if (m_pg[15]) ir = 1; m_ff = ~m_ff; c = 0;
                end else if (md == 2 && nx == m_cmpa) begin
                    st[3] = 1; if (m_wd[15]) ir = 1; c = 0;
                end
            end
            if (bus_wr) begin
                case (w)
                    0:  m_ctrl = bus_wdata[7:0] & 8'hEF;
                    2:  m_cmpa = bus_wdata[23:0];
                    3:  m_cmpb = bus_wdata[23:0];
                    4:  m_iv = bus_wdata & 32'h8001;
                    8:  m_div = bus_wdata[2:0];
                    12: m_pg = bus_wdata & 32'hC001;
                    16: m_wd = bus_wdata & 32'h8080;
                    default: ;
                endcase
            end
            m_cnt = c; m_st = st; m_irq = ir;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            n_tests++;
            if (irq !== m_irq || ff_out !== m_ff || bus_rdata !== m_read(bus_addr)) begin
                n_fail++;
                $display("FAIL R10/R6/R11 model at %0t: irq %b/%b ff %b/%b rdata %h/%h",
                         $time, irq, m_irq, ff_out, m_ff, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_int = 1'b1;
        repeat (n) @(negedge clk);
        tick_int = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd("R1 ctrl", 8'h00, 32'h0);
        chk_rd("R1 cmpA", 8'h08, 32'hFFFFFF);
        chk_rd("R1 cmpB", 8'h0C, 32'hFFFFFF);
        chk_rd("R1 count", 8'hF0, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 ff", {31'h0, ff_out}, 32'h0);

        // R2 control masking; R8 off mode frozen
        wr(8'h00, 32'hFF);
        chk_rd("R2 ctrl bit4", 8'h00, 32'hEF);
        ticks(20);
        chk_rd("R8 off count", 8'hF0, 32'h0);

        // R5 interval hold without zero-clear
        wr(8'h08, 32'h3);
        wr(8'h10, 32'h8000);
        wr(8'h00, 32'h80);
        ticks(10);
        chk_rd("R5 hold at A", 8'hF0, 32'h3);
        chk_rd("R5 status bit0", 8'h04, 32'h1);
        chk("R10 irq set", {31'h0, irq}, 32'h1);
        ticks(5);
        chk_rd("R5 still held", 8'hF0, 32'h3);
        chk("R10 irq level", {31'h0, irq}, 32'h1);
        wr(8'h04, 32'h0);
        chk_rd("R9 status cleared", 8'h04, 32'h0);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);

        // R3 clear on stop
        wr(8'h00, 32'h20);
        chk_rd("R3 count cleared", 8'hF0, 32'h0);

        // R4 prescaler
        wr(8'h08, 32'h1000);
        wr(8'h20, 32'h1);
        wr(8'h00, 32'hC0);
        ticks(40);
        chk_rd("R4 divide by 4", 8'hF0, 32'd10);
        wr(8'h00, 32'h20);
        wr(8'h00, 32'h80);
        ticks(7);
        chk_rd("R4 no divide", 8'hF0, 32'd7);
        wr(8'h00, 32'h20);
        wr(8'h00, 32'hC4);
        @(negedge clk);
        tick_int = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); tick_ext = 1'b1;
            @(negedge clk); tick_ext = 1'b0;
        end
        tick_int = 1'b0;
        chk_rd("R4 external", 8'hF0, 32'd6);

        // R6 pulse mode
        wr(8'h00, 32'h20);
        wr(8'h08, 32'h2);
        wr(8'h0C, 32'h5);
        wr(8'h30, 32'h4000);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h81);
        ticks(2);
        chk_rd("R6 count at A", 8'hF0, 32'h2);
        chk("R6 ff toggled", {31'h0, ff_out}, 32'h1);
        chk_rd("R6 status A", 8'h04, 32'h2);
        chk("R6 irq A", {31'h0, irq}, 32'h1);
        wr(8'h04, 32'h0);
        ticks(3);
        chk_rd("R6 count cleared at B", 8'hF0, 32'h0);
        chk("R6 ff back", {31'h0, ff_out}, 32'h0);
        chk_rd("R6 status B", 8'h04, 32'h4);
        chk("R6 irq B disabled", {31'h0, irq}, 32'h0);

        // R7 watchdog
        wr(8'h00, 32'h20);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h4);
        wr(8'h40, 32'h8000);
        wr(8'h00, 32'h02);
        ticks(4);
        chk_rd("R7 expiry count", 8'hF0, 32'h0);
        chk_rd("R7 status bit3", 8'h04, 32'h8);
        chk("R7 irq", {31'h0, irq}, 32'h1);
        wr(8'h04, 32'h0);
        ticks(2);
        chk_rd("R7 running", 8'hF0, 32'h2);
        wr(8'h40, 32'h0080);
        ticks(5);
        chk_rd("R7 halted", 8'hF0, 32'h2);
        wr(8'h00, 32'h82);
        ticks(1);
        chk_rd("R7 run overrides", 8'hF0, 32'h3);

        // R9 status write racing an event
        wr(8'h00, 32'h20);
        wr(8'h08, 32'h1);
        wr(8'h10, 32'h8001);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h80);
        @(negedge clk);
        tick_int = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h04, 32'h0);
        bus_addr = 8'h04;
        #1 chk("R9 event wins status", bus_rdata, 32'h1);
        chk("R9 event wins irq", {31'h0, irq}, 32'h1);
        tick_int = 1'b0;

        // R11 compare width, unmapped offsets
        wr(8'h14, 32'hFFFFFFFF);
        chk_rd("R11 unmapped read", 8'h14, 32'h0);
        chk_rd("R11 unmapped 0x24", 8'h24, 32'h0);
        chk_rd("R11 ctrl untouched", 8'h00, 32'h80);
        wr(8'h08, 32'hABCDEF12);
        chk_rd("R11 compare width", 8'h08, 32'hCDEF12);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            tick_int = ($urandom % 3) != 0;
            tick_ext = ($urandom % 4) == 0;
            if (($urandom % 8) == 0) begin
                int k;
                logic [7:0] ofs [0:9];
                ofs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h40, 8'hF0, 8'h18};
                k = $urandom % 10;
                bus_wr = 1'b1; bus_addr = ofs[k];
                bus_wdata = (k == 2 || k == 3) ? ($urandom % 12) : $urandom;
            end else begin
                bus_wr = 1'b0;
                bus_addr = (($urandom % 2) == 0) ? 8'hF0 : 8'h04;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0; tick_int = 1'b0; tick_ext = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule